// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is the serial engine of an SPI master. The host writes one byte at a time into a single transmit holding buffer. The block moves that byte into its shift register and runs an eight-bit frame. During the frame it drives the serial clock from an internal divider, shifts data out on MOSI and captures data from MISO. Three mode inputs set the frame's shape. `cpol` sets the level of the serial clock when it is idle. `cpha` sets which clock edges launch data and which edges sample it. `lsbFirst` sets the bit order. When `autoSelEn` is high, an active-low select output frames each transfer.

The received byte is copied to a receive register at the end of each frame, and a receive-full flag is raised. The host reads the register and clears the flag with `rxRead`. With `cpha` high, a byte that is already waiting in the buffer when a frame ends is sent straight after it. There is no idle time between the two frames and the select stays asserted. With `cpha` low, the select is always released between frames.

Top module: `spi_master_core`

## Requirements
- R1: After reset, `ssN` is 1, `sclk` equals `cpol`, `txEmpty` is 1, `rxFull` is 0 and `busy` is 0.
- R2: Outside a frame `sclk` rests at `cpol`. A frame has exactly 16 `sclk` transitions, and each half period lasts `HALF_DIV` clock cycles.
- R3: With `cpha`=0, the first data bit is on `mosi` from the cycle the frame starts (select falling), before any `sclk` edge. Odd-numbered edges (1,3,…,15) sample `miso`. Even-numbered edges (2,…,14) launch the next bit.
- R4: With `cpha`=1, odd-numbered edges (1,…,15) launch a bit on `mosi`, so edge 1 launches the first bit. Even-numbered edges (2,…,16) sample `miso`. Apart from frame start, `mosi` changes only on `sclk` edges.
- R5: With `lsbFirst`=0, bit 7 goes first on both `mosi` and `miso`. With `lsbFirst`=1, bit 0 goes first. The received byte is assembled in the same order.
- R6: With `autoSelEn`=1, `ssN` falls when a frame starts. The first `sclk` edge comes `HALF_DIV` cycles later. `ssN` rises `HALF_DIV` cycles after the 16th edge. With `autoSelEn`=0, `ssN` stays 1.
- R7: With `cpha`=1, if the buffer holds a byte when the 16th edge occurs, the next frame's edge 1 follows `HALF_DIV` cycles after that edge. `ssN` stays low across the boundary.
- R8: With `cpha`=0, `ssN` rises after every frame, even when a byte is waiting. The next frame starts no sooner than `HALF_DIV` cycles after that rise.
- R9: At the 16th edge, the received byte goes to `rxData` and `rxFull` is set. A later frame overwrites `rxData` even if `rxFull` is still set. `rxRead` clears `rxFull`.
- R10: A `wrStrobe` while `txEmpty` is 0 is ignored. `txEmpty` returns to 1 when the buffered byte moves into the shifter at frame start.
- R11: `busy` is 1 from frame start until one half period after the select release, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | Clock phase select |
| lsbFirst | input | 1 | 1: least significant bit first |
| autoSelEn | input | 1 | Enables the automatic select output |
| wrStrobe | input | 1 | Writes `wrData` into the transmit buffer |
| wrData | input | DATA_W | Byte to transmit |
| rxRead | input | 1 | Clears `rxFull` |
| miso | input | 1 | Serial data from the slave |
| txEmpty | output | 1 | Transmit buffer can accept a byte |
| rxData | output | DATA_W | Last received byte |
| rxFull | output | 1 | A received byte is waiting |
| busy | output | 1 | A frame or its trailing time is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |

## Verification
A behavioural loopback slave follows the select and the clock-edge count. It returns a known byte and captures what it receives. A design with swapped edge roles, a wrong bit order or a missing first-bit launch under `cpha`=0 therefore returns a corrupted byte in one of the eight mode combinations. Edge timestamps show a select released too early or too late, or an edge-1 delay that is wrong. With `cpha`=1, a chained second byte must follow after exactly one half period. A design that idles or releases the select there shows an extra select rise or a longer gap. With `cpha`=0, the same chained case must show two releases. A second write while the buffer is full must not replace the waiting byte, and an unread receive byte must be overwritten.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  // Strobes from the control to the datapath; at most one of load/drive per cycle
  typedef struct packed {
    logic load;    // move buffer into shifter (frame start)
    logic drive;   // launch next bit on mosi
    logic sample;  // capture miso
    logic done;    // last edge of the frame
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2,
    ST_GAP   = 2'd3
  } ctrlState_t;
endpackage

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       bufFull,
  output dpStrobe_t  strb,
  output logic       sclk,
  output logic       selActive,
  output logic       busy
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  ctrlState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic phase;
  logic tick, edgeTick, lastEdge, oddEdge, startIdle, chain;

  assign tick      = (divCnt == DIV_W'(HALF_DIV - 1));
  assign edgeTick  = (state == ST_XFER) && tick;
  assign lastEdge  = (edgeCnt == EDGE_W'(EDGES - 1));
  assign oddEdge   = ~edgeCnt[0];  // edge number edgeCnt+1 is odd
  assign startIdle = (state == ST_IDLE) && bufFull;
  assign chain     = edgeTick && lastEdge && cpha && bufFull;

  always_comb begin
    strb.load   = startIdle || chain;
    strb.sample = edgeTick && (cpha ? ~oddEdge : oddEdge);
    strb.drive  = edgeTick && ~lastEdge && (cpha ? oddEdge : ~oddEdge);
    strb.done   = edgeTick && lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
    end else begin
      if (state == ST_IDLE) divCnt <= '0;
      else divCnt <= tick ? '0 : divCnt + 1'b1;
      case (state)
        ST_IDLE: if (startIdle) begin
          state   <= ST_XFER;
          edgeCnt <= '0;
        end
        ST_XFER: if (tick) begin
          phase <= ~phase;
          if (lastEdge) begin
            edgeCnt <= '0;
            if (!chain) state <= ST_TRAIL;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
        ST_TRAIL: if (tick) state <= ST_GAP;
        default:  if (tick) state <= ST_IDLE;
      endcase
    end
  end

  assign sclk      = cpol ^ phase;
  assign selActive = (state == ST_XFER) || (state == ST_TRAIL);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/spi_master_dp.sv
module spi_master_dp
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  dpStrobe_t         strb,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxRead,
  input  logic              miso,
  output logic              bufFull,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull
);
  logic [DATA_W-1:0] bufReg, txSh, rxSh, rxNext;

  function automatic logic headBit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] dropHead(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  always_comb begin
    rxNext = rxSh;
    if (strb.sample)
      rxNext = lsbFirst ? {miso, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg  <= '0;
      bufFull <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      mosi    <= 1'b0;
      rxData  <= '0;
      rxFull  <= 1'b0;
    end else begin
      if (strb.load) begin
        bufFull <= 1'b0;
        if (cpha) begin
          txSh <= bufReg;
        end else begin
          mosi <= headBit(bufReg, lsbFirst);
          txSh <= dropHead(bufReg, lsbFirst);
        end
      end else if (wrStrobe && !bufFull) begin
        bufReg  <= wrData;
        bufFull <= 1'b1;
      end
      if (strb.drive) begin
        mosi <= headBit(txSh, lsbFirst);
        txSh <= dropHead(txSh, lsbFirst);
      end
      rxSh <= rxNext;
      if (strb.done) begin
        rxData <= rxNext;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_master_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic              autoSelEn,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxRead,
  input  logic              miso,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              ssN
);
  dpStrobe_t strb;
  logic bufFull, selActive;

  spi_master_ctrl #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .bufFull(bufFull),
    .strb(strb), .sclk(sclk), .selActive(selActive), .busy(busy)
  );

  spi_master_dp #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .cpha(cpha), .lsbFirst(lsbFirst), .strb(strb),
    .wrStrobe(wrStrobe), .wrData(wrData), .rxRead(rxRead), .miso(miso),
    .bufFull(bufFull), .mosi(mosi), .rxData(rxData), .rxFull(rxFull)
  );

  assign txEmpty = ~bufFull;
  assign ssN     = ~(autoSelEn & selActive);
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic autoSelEn,
  input logic txEmpty,
  input logic rxFull,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic ssN
);
  // R2
  idle_clock_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R6
  idle_select_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || !autoSelEn) |-> ssN);

  // R4
  mosi_edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && $stable(sclk)) |-> $stable(mosi));

  // R8
  select_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |=> ssN);

  // R9
  rx_full_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> busy);

  // R10
  buffer_load_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> busy);
endmodule

bind spi_master_core spi_master_chk core_chk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .autoSelEn(autoSelEn),
  .txEmpty(txEmpty), .rxFull(rxFull), .busy(busy), .sclk(sclk),
  .mosi(mosi), .ssN(ssN)
);

// File: tb/spi_master_core_test.sv
module spi_master_core_test;
  localparam int CLK_NS = 10;
  localparam int HALF = 3;
  localparam time HALF_T = HALF * CLK_NS;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsbFirst = 1'b0, autoSelEn = 1'b1;
  logic wrStrobe = 1'b0, rxRead = 1'b0;
  logic [7:0] wrData = '0;
  logic slvMiso = 1'b0;
  logic txEmpty, rxFull, busy, sclk, mosi, ssN;
  logic [7:0] rxData;

  int testsRun = 0, testsFailed = 0;

  spi_master_core #(.DATA_W(8), .HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst),
    .autoSelEn(autoSelEn), .wrStrobe(wrStrobe), .wrData(wrData), .rxRead(rxRead),
    .miso(slvMiso), .txEmpty(txEmpty), .rxData(rxData), .rxFull(rxFull),
    .busy(busy), .sclk(sclk), .mosi(mosi), .ssN(ssN)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // ---------------- behavioural loopback slave ----------------
  logic [7:0] reply [4];
  logic [7:0] capt [4];
  time edge1T [4];
  time edge16T [4];
  int sEdge = 0, sFrame = 0, rawEdges = 0, ssRises = 0;
  logic [7:0] sCap = '0;
  time lastEdgeT = 0, ssRiseT = 0, ssFallT = 0;

  function automatic logic bitOf(input logic [7:0] v, input int idx, input logic lsb);
    return lsb ? v[idx] : v[7-idx];
  endfunction

  always @(negedge ssN) begin
    ssFallT = $time;
    sEdge = 0;
    sCap = '0;
    if (!cpha) slvMiso = bitOf(reply[sFrame], 0, lsbFirst);
  end

  always @(posedge ssN) begin
    ssRiseT = $time;
    ssRises++;
  end

  always @(sclk) begin
    rawEdges++;
    if (!ssN) begin
      sEdge++;
      lastEdgeT = $time;
      if (sEdge == 1) edge1T[sFrame] = $time;
      if ((sEdge % 2 == 1) != cpha)
        sCap = lsbFirst ? {mosi, sCap[7:1]} : {sCap[6:0], mosi};
      else if (sEdge < 16)
        slvMiso = bitOf(reply[sFrame], cpha ? (sEdge - 1) / 2 : sEdge / 2, lsbFirst);
      if (sEdge == 16) begin
        edge16T[sFrame] = $time;
        capt[sFrame] = sCap;
        sFrame = (sFrame + 1) % 4;
        sEdge = 0;
        sCap = '0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic resetSlave();
    sFrame = 0;
    sEdge = 0;
    for (int i = 0; i < 4; i++) capt[i] = 8'hxx;
  endtask

  // {cpol, cpha, lsbFirst, tx, reply}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b0, 1'b1, 1'b0, 8'h13, 8'hC8},
    {1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F},
    {1'b1, 1'b0, 1'b0, 8'h6B, 8'hD2},
    {1'b1, 1'b0, 1'b1, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b0, 8'hE7, 8'h19},
    {1'b1, 1'b1, 1'b1, 8'h4C, 8'hB3}
  };

  initial begin
    #(CLK_NS * 150000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    resetSlave();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ssN", ssN, 1);
    check("R1 sclk", sclk, cpol);
    check("R1 txEmpty", txEmpty, 1);
    check("R1 rxFull", rxFull, 0);
    check("R1 busy", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 8; v++) begin
      int e0;
      cpol = VEC[v][18];
      cpha = VEC[v][17];
      lsbFirst = VEC[v][16];
      @(negedge clk);
      resetSlave();
      reply[0] = VEC[v][7:0];
      e0 = rawEdges;
      writeByte(VEC[v][15:8]);
      waitIdle();
      check($sformatf("R3/R4/R5 slave capture v%0d", v), capt[0], VEC[v][15:8]);
      check($sformatf("R3/R4/R5 rxData v%0d", v), rxData, VEC[v][7:0]);
      check($sformatf("R9 rxFull v%0d", v), rxFull, 1);
      check($sformatf("R2 edge count v%0d", v), rawEdges - e0, 16);
      check($sformatf("R2 idle level v%0d", v), sclk, cpol);
      check($sformatf("R6 first edge delay v%0d", v), 32'(edge1T[0] - ssFallT), 32'(HALF_T));
      check($sformatf("R6 release delay v%0d", v), 32'(ssRiseT - lastEdgeT), 32'(HALF_T));
      check($sformatf("R11 busy end v%0d", v), busy, 0);
      @(negedge clk); rxRead = 1'b1;
      @(negedge clk); rxRead = 1'b0;
      check($sformatf("R9 rxRead clears v%0d", v), rxFull, 0);
    end

    // R7 gap-free back-to-back with cpha=1
    begin
      int r0;
      cpol = 1'b0; cpha = 1'b1; lsbFirst = 1'b0;
      @(negedge clk);
      resetSlave();
      reply[0] = 8'h5A; reply[1] = 8'hC3;
      r0 = ssRises;
      writeByte(8'h96);
      while (!txEmpty || !busy) @(negedge clk);
      writeByte(8'h2D);
      waitIdle();
      check("R7 select rises once", ssRises - r0, 1);
      check("R7 gap-free edge spacing", 32'(edge1T[1] - edge16T[0]), 32'(HALF_T));
      check("R7 first byte", capt[0], 8'h96);
      check("R7 second byte", capt[1], 8'h2D);
      check("R7 rxData second", rxData, 8'hC3);
    end

    // R8 R10 R9: cpha=0 releases between bytes, ignored write, overwrite
    begin
      int r0;
      time fall2;
      cpol = 1'b1; cpha = 1'b0; lsbFirst = 1'b1;
      @(negedge clk);
      resetSlave();
      reply[0] = 8'h11; reply[1] = 8'hE4;
      r0 = ssRises;
      writeByte(8'h3B);
      while (!txEmpty || !busy) @(negedge clk);
      writeByte(8'hD6);
      check("R10 buffer full after write", txEmpty, 0);
      writeByte(8'h77);  // ignored
      while (ssRises == r0) @(negedge clk);
      while (ssN) @(negedge clk);
      fall2 = ssFallT;
      check("R8 gap after release", 32'(fall2 - ssRiseT >= HALF_T), 1);
      waitIdle();
      check("R8 select rises twice", ssRises - r0, 2);
      check("R10 ignored write", capt[1], 8'hD6);
      check("R10 buffer empty", txEmpty, 1);
      check("R9 overwrite unread", rxData, 8'hE4);
      check("R9 still full", rxFull, 1);
    end

    // R6 automatic select disabled
    begin
      int r0, e0;
      autoSelEn = 1'b0;
      cpha = 1'b1;
      @(negedge clk);
      r0 = ssRises; e0 = rawEdges;
      writeByte(8'h42);
      while (busy) begin
        if (!ssN) r0 = -100;
        @(negedge clk);
      end
      waitIdle();
      check("R6 select held high", ssRises - r0, 0);
      check("R2 edges without select", rawEdges - e0, 16);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule